// File: doc/BRIEF.md
# Banked Per-Core Private Timer Window

This block holds one private down-counting timer for each processor core. It decodes the register space of all of these timers from one request port. Every timer owns a 32-byte window of word registers. Window 0 is an alias: an access there is steered to the timer of whichever core issued it, and that core is named by a core-ID input sampled with each request. Window k+1 always reaches the timer of core k, whatever the requester. The block drives one interrupt line per core, with bit k of the vector belonging to core k.

Each timer has four registers, chosen by address bits [4:2]:

| Offset | Register | Fields |
|--------|----------|--------|
| 0x0 | reload | Writing it sets both the reload value and the counter. |
| 0x4 | counter | Current count, writable. |
| 0x8 | control | bit 0 run, bit 1 auto-reload, bit 2 interrupt enable, bits [15:8] prescale. |
| 0xC | status | bit 0 is the expiry flag, cleared by writing 1. |

The other offsets in a window read as zero. Only full-word accesses are accepted. A request with any other size code is rejected, and so is an alias access from a core ID at or above the configured core count. A rejected request returns zero, changes nothing, and raises a one-cycle error pulse. A window past the last configured core reads as zero and ignores writes, with no error. A core count outside 1..MAX_CORES stops elaboration.

Top module: `mpt_banked_timer_window`

## Requirements
- R1: Address bits [4:2] select the register in a window: 0 reload, 1 counter, 2 control, 3 status. Offsets 4 to 7 read zero. Control reads back only bits 0, 1, 2 and 15:8, with zeros elsewhere.
- R2: Window 0 (address bits above bit 4 equal to zero) reaches the timer of core `req_core_id`. Window k+1 reaches the timer of core k for every requester.
- R3: An alias access with `req_core_id` >= NUM_CORES reads zero, drops its write, and drives `err_o` high in the following cycle.
- R4: A request whose `req_size` is not 2 (32-bit) reads zero, drops its write, and drives `err_o` high in the following cycle.
- R5: A window above NUM_CORES reads zero and ignores writes, and `err_o` stays low.
- R6: `irq_o[k]` is high exactly when core k's status flag and its interrupt-enable bit are both set.
- R7: While run is set, the counter drops by one every prescale+1 cycles, counted from the edge that wrote control. While run is clear, the counter holds.
- R8: When a tick takes the counter from 1, the status flag sets. The counter then loads the reload value in auto-reload mode, or stays at 0 in one-shot mode.
- R9: Writing status with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag as it was.
- R10: After synchronous reset, every register is zero, and `irq_o`, `rsp_valid` and `err_o` are low.
- R11: A read request returns its data on `rsp_rdata` with `rsp_valid` high one cycle later. The data is the register value from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address: window in the upper bits, register in [4:2] |
| req_size | input | 2 | Size code, 2 means 32-bit |
| req_core_id | input | CID_W | Index of the requesting core |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| err_o | output | 1 | One-cycle pulse for a rejected request |
| irq_o | output | NUM_CORES | Interrupt per core, bit k for core k |

## Verification
The bench is built with three cores and room for four. Every pairing of window and core ID is read after each core's reload register has been given a distinct value. This separates alias steering, fixed windows, an absent core's window and an out-of-range requester. Alias writes are then swept over every core ID, and each core is read back through its fixed window to show that only the right timer changed. Countdown is sampled for several prescale and idle-length pairs, so an off-by-one in the tick period gives a different count. One-shot runs, auto-reload runs and status clears are timed so that the interrupt vector shows both the per-core ordering and the gating by interrupt enable.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

    localparam int DATA_W      = 32;
    localparam int WIN_LSB     = 5;
    localparam int PRE_W       = 8;
    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef enum logic [2:0] {
        REG_RELOAD = 3'd0,
        REG_COUNT  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_STATUS = 3'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PRE_W-1:0] prescale;
        logic             irq_en;
        logic             auto_rl;
        logic             run;
    } tmr_ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_to_word(input tmr_ctrl_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = c.run;
        w[1]     = c.auto_rl;
        w[2]     = c.irq_en;
        w[15:8]  = c.prescale;
        return w;
    endfunction

    function automatic tmr_ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        tmr_ctrl_t c;
        c.run      = w[0];
        c.auto_rl  = w[1];
        c.irq_en   = w[2];
        c.prescale = w[15:8];
        return c;
    endfunction

endpackage

// File: rtl/mpt_addr_decode.sv
module mpt_addr_decode
    import mpt_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int WIN_W     = 3,
    parameter int CID_W     = 2
) (
    input  logic                 req_valid,
    input  logic [WIN_W-1:0]     req_win,
    input  logic [1:0]           req_size,
    input  logic [CID_W-1:0]     req_core_id,
    output logic                 hit_o,
    output logic [CID_W-1:0]     tgt_core_o,
    output logic [NUM_CORES-1:0] sel_oh_o,
    output logic                 err_o
);

    logic [31:0] win_ext;
    logic [31:0] cid_ext;
    logic        size_ok;
    logic        is_alias;
    logic        in_range;

    always_comb begin
        win_ext  = 32'(req_win);
        cid_ext  = 32'(req_core_id);
        size_ok  = (req_size == SIZE_WORD);
        is_alias = (win_ext == 32'd0);
        if (is_alias) begin
            tgt_core_o = req_core_id;
            in_range   = (cid_ext < 32'(NUM_CORES));
        end else begin
            tgt_core_o = CID_W'(win_ext - 32'd1);
            in_range   = ((win_ext - 32'd1) < 32'(NUM_CORES));
        end
        hit_o = req_valid && size_ok && in_range;
        err_o = req_valid && (!size_ok || (is_alias && !in_range));
    end

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_sel
        assign sel_oh_o[k] = hit_o && (tgt_core_o == CID_W'(k));
    end

endmodule

// File: rtl/mpt_private_timer.sv
module mpt_private_timer
    import mpt_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [2:0]        acc_reg,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_word_o,
    output logic              irq_o
);

    tmr_ctrl_t          ctrl_q;
    logic [COUNT_W-1:0] reload_q;
    logic [COUNT_W-1:0] count_q;
    logic [PRE_W-1:0]   pre_q;
    logic               status_q;

    logic wr;
    logic cnt_wr;
    logic ctl_wr;
    logic clr_wr;
    logic tick;
    logic expire;

    always_comb begin
        wr     = acc_en && acc_wr;
        cnt_wr = wr && ((acc_reg == REG_RELOAD) || (acc_reg == REG_COUNT));
        ctl_wr = wr && (acc_reg == REG_CTRL);
        clr_wr = wr && (acc_reg == REG_STATUS) && acc_wdata[0];
        tick   = ctrl_q.run && (pre_q == ctrl_q.prescale);
        expire = tick && (count_q == COUNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (cnt_wr || ctl_wr || !ctrl_q.run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            count_q  <= '0;
        end else if (wr && (acc_reg == REG_RELOAD)) begin
            reload_q <= COUNT_W'(acc_wdata);
            count_q  <= COUNT_W'(acc_wdata);
        end else if (wr && (acc_reg == REG_COUNT)) begin
            count_q  <= COUNT_W'(acc_wdata);
        end else if (tick && (count_q != '0)) begin
            if (expire) begin
                count_q <= ctrl_q.auto_rl ? reload_q : '0;
            end else begin
                count_q <= count_q - COUNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctl_wr) begin
            ctrl_q <= word_to_ctrl(acc_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 1'b0;
        end else if (expire && !cnt_wr) begin
            status_q <= 1'b1;
        end else if (clr_wr) begin
            status_q <= 1'b0;
        end
    end

    always_comb begin
        case (acc_reg)
            REG_RELOAD: rd_word_o = DATA_W'(reload_q);
            REG_COUNT:  rd_word_o = DATA_W'(count_q);
            REG_CTRL:   rd_word_o = ctrl_to_word(ctrl_q);
            REG_STATUS: rd_word_o = DATA_W'(status_q);
            default:    rd_word_o = '0;
        endcase
    end

    assign irq_o = status_q && ctrl_q.irq_en;

    // R7: a stopped timer keeps its count unless software writes it
    assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !cnt_wr) |=> $stable(count_q));

    // R8: one-shot expiry parks at zero with the flag raised
    assert_oneshot_park_R8: assert property (@(posedge clk) disable iff (rst)
        (expire && !ctrl_q.auto_rl && !cnt_wr) |=> (count_q == '0) && status_q);

    // R8: auto-reload expiry restarts from the reload value
    assert_periodic_reload_R8: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_q.auto_rl && !cnt_wr && !ctl_wr) |=> (count_q == $past(reload_q)) && status_q);

    // R9: a clear with no coincident expiry drops the flag
    assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !expire) |=> !status_q);

endmodule

// File: rtl/mpt_rdata_mux.sv
module mpt_rdata_mux
    import mpt_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CID_W     = 2
) (
    input  logic [NUM_CORES-1:0][DATA_W-1:0] words_i,
    input  logic [CID_W-1:0]                 sel_i,
    input  logic                             hit_i,
    output logic [DATA_W-1:0]                word_o
);

    always_comb begin
        word_o = '0;
        for (int k = 0; k < NUM_CORES; k++) begin
            if (hit_i && (sel_i == CID_W'(k))) begin
                word_o = words_i[k];
            end
        end
    end

endmodule

// File: rtl/mpt_banked_timer_window.sv
module mpt_banked_timer_window
    import mpt_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int MAX_CORES = 4,
    parameter int COUNT_W   = 32,
    localparam int CID_W    = (MAX_CORES > 1) ? $clog2(MAX_CORES) : 1,
    localparam int WIN_W    = $clog2(MAX_CORES + 1),
    localparam int ADDR_W   = WIN_W + WIN_LSB
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic [CID_W-1:0]     req_core_id,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 err_o,
    output logic [NUM_CORES-1:0] irq_o
);

    if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_cfg_bad
        $error("core count %0d outside 1..%0d", NUM_CORES, MAX_CORES);
    end
    if (COUNT_W < 1 || COUNT_W > DATA_W) begin : g_cnt_bad
        $error("counter width %0d outside 1..%0d", COUNT_W, DATA_W);
    end

    logic [WIN_W-1:0]                 win;
    logic [2:0]                       reg_idx;
    logic                             hit;
    logic [CID_W-1:0]                 tgt_core;
    logic [NUM_CORES-1:0]             sel_oh;
    logic                             acc_err;
    logic [NUM_CORES-1:0][DATA_W-1:0] rd_words;
    logic [DATA_W-1:0]                mux_word;

    assign win     = req_addr[ADDR_W-1:WIN_LSB];
    assign reg_idx = req_addr[WIN_LSB-1:2];

    mpt_addr_decode #(
        .NUM_CORES (NUM_CORES),
        .WIN_W     (WIN_W),
        .CID_W     (CID_W)
    ) decode_i (
        .req_valid   (req_valid),
        .req_win     (win),
        .req_size    (req_size),
        .req_core_id (req_core_id),
        .hit_o       (hit),
        .tgt_core_o  (tgt_core),
        .sel_oh_o    (sel_oh),
        .err_o       (acc_err)
    );

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
        mpt_private_timer #(
            .COUNT_W (COUNT_W)
        ) timer_i (
            .clk       (clk),
            .rst       (rst),
            .acc_en    (sel_oh[k]),
            .acc_wr    (req_write),
            .acc_reg   (reg_idx),
            .acc_wdata (req_wdata),
            .rd_word_o (rd_words[k]),
            .irq_o     (irq_o[k])
        );
    end

    mpt_rdata_mux #(
        .NUM_CORES (NUM_CORES),
        .CID_W     (CID_W)
    ) rmux_i (
        .words_i (rd_words),
        .sel_i   (tgt_core),
        .hit_i   (hit),
        .word_o  (mux_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            err_o     <= 1'b0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write && hit) ? mux_word : '0;
            err_o     <= acc_err;
        end
    end

    // R2: at most one timer is strobed by any request
    assert_single_target_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_oh));

    // R3: alias access from an absent core is flagged and reads zero
    assert_alias_err_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (win == '0) && (32'(req_core_id) >= 32'(NUM_CORES)))
        |=> err_o && (rsp_rdata == '0));

    // R4: a non-word access is flagged and reads zero
    assert_bad_size_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_size != SIZE_WORD)) |=> err_o && (rsp_rdata == '0));

    // R5: windows past the last core are silent and empty
    assert_absent_window_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_size == SIZE_WORD) && (32'(win) > 32'(NUM_CORES)))
        |=> !err_o && (rsp_rdata == '0));

    // R11: every read is answered on the next cycle
    assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

endmodule

// File: tb/mpt_banked_timer_window_tb_top.sv
module mpt_banked_timer_window_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NC         = 3;
    localparam int MC         = 4;
    localparam int CW         = 16;
    localparam int CIDW       = 2;
    localparam int AW         = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [1:0]      req_size = 2'd2;
    logic [CIDW-1:0] req_core_id = '0;
    logic [31:0]     req_wdata = '0;
    logic            rsp_valid;
    logic [31:0]     rsp_rdata;
    logic            err_o;
    logic [NC-1:0]   irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpt_banked_timer_window #(
        .NUM_CORES (NC),
        .MAX_CORES (MC),
        .COUNT_W   (CW)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_core_id (req_core_id),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .err_o       (err_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic [31:0] last_rd;
    bit          last_err;
    bit          last_rv;

    task automatic acc(input bit wr, input int win, input int off, input int cid,
                       input logic [1:0] sz, input logic [31:0] wd);
        req_valid   = 1'b1;
        req_write   = wr;
        req_addr    = AW'((win << 5) | (off << 2));
        req_size    = sz;
        req_core_id = CIDW'(cid);
        req_wdata   = wd;
        @(negedge clk);
        last_rd     = rsp_rdata;
        last_err    = err_o;
        last_rv     = rsp_valid;
        req_valid   = 1'b0;
        req_write   = 1'b0;
    endtask

    task automatic wr_reg(input int win, input int off, input logic [31:0] wd);
        acc(1'b1, win, off, 0, 2'd2, wd);
    endtask

    task automatic rd_reg(input int win, input int off);
        acc(1'b0, win, off, 0, 2'd2, 32'd0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 32'(rsp_valid), 0);
        chk(err_o == 1'b0, "R10", "err in reset", 32'(err_o), 0);
        chk(irq_o == '0, "R10", "irq in reset", 32'(irq_o), 0);
        rst = 1'b0;
        for (int k = 0; k < NC; k++) begin
            for (int r = 0; r < 4; r++) begin
                rd_reg(k + 1, r);
                chk(last_rd == 32'd0, "R10", "register after reset", last_rd, 0);
            end
        end

        // R2: distinct reload per core, then every window x core-id pair
        for (int k = 0; k < NC; k++) wr_reg(k + 1, 0, 32'h100 + 32'(k) * 32'h11);
        for (int w = 0; w < 8; w++) begin
            for (int c = 0; c < 4; c++) begin
                logic [31:0] exp_d;
                bit          exp_e;
                exp_e = 1'b0;
                if (w == 0) begin
                    if (c < NC) exp_d = 32'h100 + 32'(c) * 32'h11;
                    else begin exp_d = 0; exp_e = 1'b1; end
                end else if (w <= NC) exp_d = 32'h100 + 32'(w - 1) * 32'h11;
                else exp_d = 0;
                acc(1'b0, w, 0, c, 2'd2, 0);
                chk(last_rd == exp_d, (w == 0) ? "R2" : ((w > NC) ? "R5" : "R2"),
                    $sformatf("read win %0d cid %0d", w, c), last_rd, exp_d);
                chk(last_err == exp_e, (w == 0 && c >= NC) ? "R3" : "R5",
                    $sformatf("err win %0d cid %0d", w, c), 32'(last_err), 32'(exp_e));
                chk(last_rv == 1'b1, "R11", "rsp_valid on read", 32'(last_rv), 1);
            end
        end

        // R3: alias write sweep across all core ids
        for (int c = 0; c < 4; c++) begin
            acc(1'b1, 0, 0, c, 2'd2, 32'h300 + 32'(c));
            chk(last_err == (c >= NC), "R3", $sformatf("alias write err cid %0d", c),
                32'(last_err), 32'(c >= NC));
        end
        for (int k = 0; k < NC; k++) begin
            rd_reg(k + 1, 0);
            chk(last_rd == 32'h300 + 32'(k), "R3", "alias write landed on own core",
                last_rd, 32'h300 + 32'(k));
        end

        // R5: writes to absent windows change nothing
        wr_reg(NC + 1, 0, 32'hBEEF);
        chk(last_err == 1'b0, "R5", "no err on absent window write", 32'(last_err), 0);
        wr_reg(7, 0, 32'hBEEF);
        for (int k = 0; k < NC; k++) begin
            rd_reg(k + 1, 0);
            chk(last_rd == 32'h300 + 32'(k), "R5", "core unchanged by absent write",
                last_rd, 32'h300 + 32'(k));
        end

        // R4: non-word sizes
        for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            acc(1'b0, 1, 0, 0, 2'(s), 0);
            chk(last_rd == 0, "R4", $sformatf("bad size %0d read", s), last_rd, 0);
            chk(last_err == 1'b1, "R4", $sformatf("bad size %0d err", s), 32'(last_err), 1);
            acc(1'b1, 1, 0, 0, 2'(s), 32'hAAAA);
            chk(last_err == 1'b1, "R4", "bad size write err", 32'(last_err), 1);
        end
        rd_reg(1, 0);
        chk(last_rd == 32'h300, "R4", "bad size write dropped", last_rd, 32'h300);
        idle(1);
        chk(err_o == 1'b0, "R3", "err is a single pulse", 32'(err_o), 0);

        // R1: offsets and control field layout
        wr_reg(2, 2, 32'h0000_0304);
        rd_reg(2, 2);
        chk(last_rd == 32'h304, "R1", "control readback", last_rd, 32'h304);
        wr_reg(2, 2, 32'hFFFF_FFFF);
        rd_reg(2, 2);
        chk(last_rd == 32'h0000_FF07, "R1", "control masked readback", last_rd, 32'h0000_FF07);
        wr_reg(2, 2, 0);
        for (int o = 4; o < 8; o++) begin
            rd_reg(2, o);
            chk(last_rd == 0, "R1", $sformatf("unused offset %0d", o), last_rd, 0);
        end
        wr_reg(2, 1, 32'h55);
        rd_reg(2, 1);
        chk(last_rd == 32'h55, "R1", "counter offset", last_rd, 32'h55);

        // R7: countdown with several prescale / wait pairs
        for (int p = 0; p < 4; p++) begin
            if (p == 2) continue;
            for (int wi = 0; wi < 2; wi++) begin
                int w;
                w = (wi == 0) ? 3 : 7;
                wr_reg(2, 2, 0);
                wr_reg(2, 1, 32'd40);
                wr_reg(2, 2, 32'(p << 8) | 32'h1);
                idle(w);
                rd_reg(2, 1);
                chk(last_rd == 32'(40 - w / (p + 1)), "R7",
                    $sformatf("count p=%0d w=%0d", p, w), last_rd, 32'(40 - w / (p + 1)));
                rd_reg(2, 1);
                chk(last_rd == 32'(40 - (w + 1) / (p + 1)), "R7",
                    $sformatf("count next p=%0d w=%0d", p, w), last_rd, 32'(40 - (w + 1) / (p + 1)));
            end
        end
        wr_reg(2, 2, 0);
        wr_reg(2, 1, 32'd9);
        idle(5);
        rd_reg(2, 1);
        chk(last_rd == 32'd9, "R7", "stopped counter holds", last_rd, 9);

        // R8 + R6: auto-reload on core 2 with interrupt enabled
        wr_reg(3, 2, 0);
        wr_reg(3, 3, 1);
        wr_reg(3, 0, 32'd3);
        wr_reg(3, 2, 32'h7);
        idle(2);
        chk(irq_o == 3'b000, "R6", "irq before expiry", 32'(irq_o), 0);
        idle(1);
        chk(irq_o == 3'b100, "R6", "irq on core 2 only", 32'(irq_o), 32'b100);
        rd_reg(3, 1);
        chk(last_rd == 32'd3, "R8", "periodic reload", last_rd, 3);
        wr_reg(3, 2, 32'h4);
        rd_reg(3, 3);
        chk(last_rd == 32'd1, "R8", "status set", last_rd, 1);
        wr_reg(3, 3, 0);
        rd_reg(3, 3);
        chk(last_rd == 32'd1, "R9", "write 0 keeps status", last_rd, 1);
        chk(irq_o == 3'b100, "R9", "irq kept", 32'(irq_o), 32'b100);
        wr_reg(3, 3, 1);
        chk(irq_o == 3'b000, "R9", "irq cleared by w1c", 32'(irq_o), 0);
        rd_reg(3, 3);
        chk(last_rd == 0, "R9", "status cleared", last_rd, 0);

        // R8 + R6: one-shot on core 0, interrupt masked then enabled
        wr_reg(1, 1, 32'd2);
        wr_reg(1, 2, 32'h1);
        idle(4);
        rd_reg(1, 1);
        chk(last_rd == 0, "R8", "one-shot parks at zero", last_rd, 0);
        acc(1'b0, 0, 3, 0, 2'd2, 0);
        chk(last_rd == 32'd1, "R2", "status via alias core 0", last_rd, 1);
        chk(irq_o == 3'b000, "R6", "masked irq stays low", 32'(irq_o), 0);
        wr_reg(1, 2, 32'h5);
        chk(irq_o == 3'b001, "R6", "irq on core 0 after enable", 32'(irq_o), 1);
        idle(3);
        rd_reg(1, 1);
        chk(last_rd == 0, "R8", "one-shot still zero", last_rd, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule